// File: doc/BRIEF.md
# Interrupt Acceptance Priority Arbiter

This block decides, once per instruction boundary, whether an interrupt is taken and which one. It watches a vector of maskable request lines and one nonmaskable line. Each maskable source has a level register that can be written, and the nonmaskable source has a fixed level. A smaller level value means a more urgent request. Among the active requests it picks the one with the smallest level. When several share that level, the one with the lowest interrupt number wins.

The winner is then checked against the CPU's current level mask. It is taken only if its level is strictly below the mask. A maskable winner also needs the global enable flag set, while a nonmaskable winner does not. Selection comes before these checks, so a blocked winner stops the whole decision: a lower-priority request is never taken in its place.

The request lines, mask, flag, boundary strobe, program counter and instruction-length class are registered at the input. Arbitration is combinational on those registers. A registered one-cycle accept pulse follows, carrying the interrupt number, its level and the return address.

Top module: `irq_accept_arbiter`

## Requirements
- R1: A synchronous active-high reset clears `take`, `take_num`, `take_lvl` and `ret_addr` to zero.
- R2: Among active requests, the one with the numerically smallest level is selected.
- R3: Among active requests that share the smallest level, the lowest interrupt number is selected. Maskable sources are numbered 0 to NUM_SRC-1 and the nonmaskable source is number NUM_SRC (32 by default).
- R4: The selected request is taken only if its level is strictly less than `lvl_mask`. A level equal to or above the mask is blocked.
- R5: A selected maskable request is blocked when `irq_en` is 0.
- R6: The nonmaskable request has the fixed level NMI_LVL (15 by default). It ignores `irq_en` but is still subject to the mask comparison of R4.
- R7: Blocking applies to the selected request only. When the winner is blocked, nothing is taken in that cycle, even if a lower-priority request would pass.
- R8: `take` rises only for a cycle whose `insn_end` was high, and it appears two clock edges after `insn_end` is driven (one input register, one output register). Each qualifying boundary produces exactly one cycle of `take`.
- R9: While `take` is low, `take_num`, `take_lvl` and `ret_addr` keep their previous values.
- R10: On a take, `ret_addr` is `pc` plus an offset chosen by `insn_len`. The codes are: 2'b00 gives +2, 2'b01 gives +4, 2'b10 gives +6, 2'b11 gives +2. The addition wraps modulo 2^PC_W.
- R11: The level register of source `lvl_sel` is loaded from `lvl_wdata` on a clock edge where `lvl_we` is high, and takes effect at the next arbitration. All level registers reset to the maximum value (31). At that value a source can never pass the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lvl_we | input | 1 | Write strobe for a level register |
| lvl_sel | input | 5 | Source whose level register is written |
| lvl_wdata | input | 5 | New level value |
| irq_req | input | 32 | Maskable request lines, bit i is source i |
| nmi_req | input | 1 | Nonmaskable request |
| lvl_mask | input | 5 | Current level mask of the CPU |
| irq_en | input | 1 | Global enable for maskable requests |
| insn_end | input | 1 | Instruction-boundary strobe |
| pc | input | 32 | Address of the current instruction |
| insn_len | input | 2 | Instruction-length class (see R10) |
| take | output | 1 | One-cycle accept pulse |
| take_num | output | 6 | Accepted interrupt number |
| take_lvl | output | 5 | Level of the accepted request |
| ret_addr | output | 32 | Next-instruction address captured at the take |

## Verification
On every cycle, the assertions check these rules:
- a take follows a registered boundary;
- a taken level is below the mask that was registered with it;
- a maskable take had the enable flag set;
- a nonmaskable take carries the fixed level;
- the held outputs do not move while `take` is low;
- reset clears everything.

Some behaviour shows only in the bench's directed scenarios, because it needs knowledge of the programmed levels:
- that the winner is really the minimum level with the lowest number;
- that a blocked winner suppresses lower-priority requests;
- that reset levels keep a source silent;
- that the return offsets are correct for each length class.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int unsigned DEF_NUM_SRC = 32;
    localparam int unsigned DEF_LVL_W   = 5;
    localparam int unsigned DEF_PC_W    = 32;
    localparam int unsigned DEF_NMI_LVL = 15;

    // Instruction-length class of the instruction that ends at a boundary
    typedef enum logic [1:0] {
        ILEN_HALF = 2'b00,   // plain instruction, +2
        ILEN_WORD = 2'b01,   // medium immediate / coprocessor, +4
        ILEN_WIDE = 2'b10,   // long immediate, +6
        ILEN_RSVD = 2'b11    // treated as plain
    } ilen_e;

endpackage

// File: rtl/irq_level_regs.sv
module irq_level_regs
    import irq_arb_pkg::*;
#(
    parameter int unsigned NUM_SRC = DEF_NUM_SRC,
    parameter int unsigned LVL_W   = DEF_LVL_W,
    parameter int unsigned SEL_W   = $clog2(NUM_SRC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [SEL_W-1:0] sel,
    input  logic [LVL_W-1:0] wdata,
    output logic [LVL_W-1:0] lvl [NUM_SRC]
);

    logic [LVL_W-1:0] lvl_d [NUM_SRC];
    logic [LVL_W-1:0] lvl_q [NUM_SRC];

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            lvl_d[i] = lvl_q[i];
            if (we && (32'(sel) == i)) begin
                lvl_d[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_SRC; i++) begin
            if (rst) begin
                lvl_q[i] <= '1;
            end else begin
                lvl_q[i] <= lvl_d[i];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            lvl[i] = lvl_q[i];
        end
    end

endmodule

// File: rtl/irq_prio_tree.sv
module irq_prio_tree #(
    parameter int unsigned N_IN  = 33,
    parameter int unsigned LVL_W = 5,
    parameter int unsigned IDX_W = $clog2(N_IN)
) (
    input  logic [N_IN-1:0]  vld,
    input  logic [LVL_W-1:0] lvl [N_IN],
    output logic             win_vld,
    output logic [IDX_W-1:0] win_idx,
    output logic [LVL_W-1:0] win_lvl
);

    localparam int unsigned LEAVES = 1 << $clog2(N_IN);
    localparam int unsigned NODES  = 2 * LEAVES;

    // heap layout: node k has children 2k and 2k+1, leaves at LEAVES..NODES-1
    logic             n_vld [NODES];
    logic [LVL_W-1:0] n_lvl [NODES];
    logic [IDX_W-1:0] n_idx [NODES];

    assign n_vld[0] = 1'b0;
    assign n_lvl[0] = '0;
    assign n_idx[0] = '0;

    for (genvar g = 0; g < LEAVES; g++) begin : g_leaf
        if (g < N_IN) begin : g_real
            assign n_vld[LEAVES+g] = vld[g];
            assign n_lvl[LEAVES+g] = lvl[g];
            assign n_idx[LEAVES+g] = IDX_W'(g);
        end else begin : g_pad
            assign n_vld[LEAVES+g] = 1'b0;
            assign n_lvl[LEAVES+g] = '1;
            assign n_idx[LEAVES+g] = '0;
        end
    end

    for (genvar k = 1; k < LEAVES; k++) begin : g_node
        logic pick_l;
        // left subtree holds smaller numbers, so it keeps ties
        assign pick_l = n_vld[2*k] &&
                        (!n_vld[2*k+1] || (n_lvl[2*k] <= n_lvl[2*k+1]));
        assign n_vld[k] = n_vld[2*k] | n_vld[2*k+1];
        assign n_lvl[k] = pick_l ? n_lvl[2*k] : n_lvl[2*k+1];
        assign n_idx[k] = pick_l ? n_idx[2*k] : n_idx[2*k+1];
    end

    assign win_vld = n_vld[1];
    assign win_idx = n_idx[1];
    assign win_lvl = n_lvl[1];

endmodule

// File: rtl/irq_ret_addr.sv
module irq_ret_addr
    import irq_arb_pkg::*;
#(
    parameter int unsigned PC_W = DEF_PC_W
) (
    input  logic [PC_W-1:0] pc,
    input  ilen_e           cls,
    output logic [PC_W-1:0] next_pc
);

    always_comb begin
        unique case (cls)
            ILEN_WORD: next_pc = pc + PC_W'(4);
            ILEN_WIDE: next_pc = pc + PC_W'(6);
            default:   next_pc = pc + PC_W'(2);
        endcase
    end

endmodule

// File: rtl/irq_accept_arbiter.sv
module irq_accept_arbiter
    import irq_arb_pkg::*;
#(
    parameter int unsigned NUM_SRC = DEF_NUM_SRC,
    parameter int unsigned LVL_W   = DEF_LVL_W,
    parameter int unsigned PC_W    = DEF_PC_W,
    parameter int unsigned NMI_LVL = DEF_NMI_LVL,
    localparam int unsigned SEL_W  = $clog2(NUM_SRC),
    localparam int unsigned N_IN   = NUM_SRC + 1,
    localparam int unsigned IDX_W  = $clog2(N_IN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lvl_we,
    input  logic [SEL_W-1:0] lvl_sel,
    input  logic [LVL_W-1:0] lvl_wdata,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic             nmi_req,
    input  logic [LVL_W-1:0] lvl_mask,
    input  logic             irq_en,
    input  logic             insn_end,
    input  logic [PC_W-1:0]  pc,
    input  logic [1:0]       insn_len,
    output logic             take,
    output logic [IDX_W-1:0] take_num,
    output logic [LVL_W-1:0] take_lvl,
    output logic [PC_W-1:0]  ret_addr
);

    localparam logic [IDX_W-1:0] NMI_NUM = IDX_W'(NUM_SRC);

    typedef struct packed {
        logic [NUM_SRC-1:0] req;
        logic               nmi;
        logic [LVL_W-1:0]   ilm;
        logic               ie;
        logic               bnd;
        logic [PC_W-1:0]    pc;
        ilen_e              ilen;
    } in_t;

    typedef struct packed {
        logic             take;
        logic [IDX_W-1:0] num;
        logic [LVL_W-1:0] lvl;
        logic [PC_W-1:0]  ret;
    } out_t;

    in_t  in_d,  in_q;
    out_t out_d, out_q;

    logic [LVL_W-1:0] src_lvl [NUM_SRC];
    logic [LVL_W-1:0] all_lvl [N_IN];
    logic             win_vld;
    logic [IDX_W-1:0] win_idx;
    logic [LVL_W-1:0] win_lvl;
    logic [PC_W-1:0]  next_pc;
    logic             win_nmi;
    logic             win_pass;

    irq_level_regs #(
        .NUM_SRC (NUM_SRC),
        .LVL_W   (LVL_W),
        .SEL_W   (SEL_W)
    ) i_lvl (
        .clk   (clk),
        .rst   (rst),
        .we    (lvl_we),
        .sel   (lvl_sel),
        .wdata (lvl_wdata),
        .lvl   (src_lvl)
    );

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            all_lvl[i] = src_lvl[i];
        end
        all_lvl[NUM_SRC] = LVL_W'(NMI_LVL);
    end

    irq_prio_tree #(
        .N_IN  (N_IN),
        .LVL_W (LVL_W),
        .IDX_W (IDX_W)
    ) i_tree (
        .vld     ({in_q.nmi, in_q.req}),
        .lvl     (all_lvl),
        .win_vld (win_vld),
        .win_idx (win_idx),
        .win_lvl (win_lvl)
    );

    irq_ret_addr #(
        .PC_W (PC_W)
    ) i_ret (
        .pc      (in_q.pc),
        .cls     (in_q.ilen),
        .next_pc (next_pc)
    );

    always_comb begin
        in_d.req  = irq_req;
        in_d.nmi  = nmi_req;
        in_d.ilm  = lvl_mask;
        in_d.ie   = irq_en;
        in_d.bnd  = insn_end;
        in_d.pc   = pc;
        in_d.ilen = ilen_e'(insn_len);

        win_nmi  = (win_idx == NMI_NUM);
        win_pass = win_vld && (win_lvl < in_q.ilm) && (win_nmi || in_q.ie);

        out_d      = out_q;
        out_d.take = in_q.bnd && win_pass;
        if (in_q.bnd && win_pass) begin
            out_d.num = win_idx;
            out_d.lvl = win_lvl;
            out_d.ret = next_pc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_q  <= '0;
            out_q <= '0;
        end else begin
            in_q  <= in_d;
            out_q <= out_d;
        end
    end

    assign take     = out_q.take;
    assign take_num = out_q.num;
    assign take_lvl = out_q.lvl;
    assign ret_addr = out_q.ret;

endmodule

// File: rtl/irq_accept_checker.sv
module irq_accept_checker #(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned LVL_W   = 5,
    parameter int unsigned PC_W    = 32,
    parameter int unsigned NMI_LVL = 15,
    localparam int unsigned IDX_W  = $clog2(NUM_SRC + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             take,
    input logic [IDX_W-1:0] take_num,
    input logic [LVL_W-1:0] take_lvl,
    input logic [PC_W-1:0]  ret_addr,
    input logic             bnd_q,
    input logic [LVL_W-1:0] ilm_q,
    input logic             ie_q
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!take && take_num == '0 && take_lvl == '0 && ret_addr == '0));

    // R8
    take_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        take |-> $past(bnd_q));

    // R4
    below_mask_chk: assert property (@(posedge clk) disable iff (rst)
        take |-> (take_lvl < $past(ilm_q)));

    // R5
    maskable_enable_chk: assert property (@(posedge clk) disable iff (rst)
        (take && take_num != IDX_W'(NUM_SRC)) |-> $past(ie_q));

    // R6
    nmi_fixed_level_chk: assert property (@(posedge clk) disable iff (rst)
        (take && take_num == IDX_W'(NUM_SRC)) |-> (take_lvl == LVL_W'(NMI_LVL)));

    // R3
    number_range_chk: assert property (@(posedge clk) disable iff (rst)
        take |-> (take_num <= IDX_W'(NUM_SRC)));

    // R9
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !take |-> ($stable(take_num) && $stable(take_lvl) && $stable(ret_addr)));

endmodule

bind irq_accept_arbiter irq_accept_checker #(
    .NUM_SRC (NUM_SRC),
    .LVL_W   (LVL_W),
    .PC_W    (PC_W),
    .NMI_LVL (NMI_LVL)
) i_chk (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .take_num (take_num),
    .take_lvl (take_lvl),
    .ret_addr (ret_addr),
    .bnd_q    (in_q.bnd),
    .ilm_q    (in_q.ilm),
    .ie_q     (in_q.ie)
);

// File: tb/test_irq_accept_arbiter.sv
module test_irq_accept_arbiter;

    logic        clk = 1'b0;
    logic        rst;
    logic        lvl_we;
    logic [4:0]  lvl_sel;
    logic [4:0]  lvl_wdata;
    logic [31:0] irq_req;
    logic        nmi_req;
    logic [4:0]  lvl_mask;
    logic        irq_en;
    logic        insn_end;
    logic [31:0] pc;
    logic [1:0]  insn_len;
    logic        take;
    logic [5:0]  take_num;
    logic [4:0]  take_lvl;
    logic [31:0] ret_addr;

    int checks = 0;
    int fails  = 0;

    logic [5:0]  m_num = '0;
    logic [4:0]  m_lvl = '0;
    logic [31:0] m_ret = '0;

    always #10 clk = ~clk;

    irq_accept_arbiter i_irq_accept_arbiter (
        .clk       (clk),
        .rst       (rst),
        .lvl_we    (lvl_we),
        .lvl_sel   (lvl_sel),
        .lvl_wdata (lvl_wdata),
        .irq_req   (irq_req),
        .nmi_req   (nmi_req),
        .lvl_mask  (lvl_mask),
        .irq_en    (irq_en),
        .insn_end  (insn_end),
        .pc        (pc),
        .insn_len  (insn_len),
        .take      (take),
        .take_num  (take_num),
        .take_lvl  (take_lvl),
        .ret_addr  (ret_addr)
    );

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_outs(input string tag, input logic exp_take);
        cmp({tag, " take"}, 32'(take), 32'(exp_take));
        cmp({tag, " num"},  32'(take_num), 32'(m_num));
        cmp({tag, " lvl"},  32'(take_lvl), 32'(m_lvl));
        cmp({tag, " ret"},  ret_addr, m_ret);
    endtask

    // called at a negedge; returns at a negedge
    task automatic prog(input int src, input int lvl);
        lvl_we    = 1'b1;
        lvl_sel   = 5'(src);
        lvl_wdata = 5'(lvl);
        @(negedge clk);
        lvl_we    = 1'b0;
    endtask

    task automatic shot(input string tag, input logic [31:0] req, input logic nmi,
                        input int ilm, input logic ie, input logic [31:0] p,
                        input int len, input logic exp_take,
                        input int exp_num, input int exp_lvl);
        irq_req  = req;
        nmi_req  = nmi;
        lvl_mask = 5'(ilm);
        irq_en   = ie;
        pc       = p;
        insn_len = 2'(len);
        insn_end = 1'b1;
        @(negedge clk);
        insn_end = 1'b0;
        @(negedge clk);
        if (exp_take) begin
            m_num = 6'(exp_num);
            m_lvl = 5'(exp_lvl);
            m_ret = p + ((len == 1) ? 32'd4 : (len == 2) ? 32'd6 : 32'd2);
        end
        check_outs(tag, exp_take);
    endtask

    task automatic t_reset();
        check_outs("R1 reset", 1'b0);
    endtask

    task automatic t_reset_levels();
        // R11: source 0 still at reset level 31 cannot pass mask 31
        shot("R11 reset level", 32'h1, 1'b0, 31, 1'b1, 32'h100, 0, 1'b0, 0, 0);
        prog(5, 10); prog(9, 4); prog(20, 4); prog(30, 12); prog(3, 15);
    endtask

    task automatic t_priority();
        shot("R3 tie low num", (32'h1 << 5) | (32'h1 << 9) | (32'h1 << 20) | (32'h1 << 30),
             1'b0, 31, 1'b1, 32'h1000, 0, 1'b1, 9, 4);
        shot("R2 min level", (32'h1 << 5) | (32'h1 << 30), 1'b0, 31, 1'b1,
             32'h2000, 1, 1'b1, 5, 10);
        // R8: pulse lasts one cycle
        @(negedge clk);
        cmp("R8 pulse end", 32'(take), 32'd0);
    endtask

    task automatic t_mask();
        shot("R4 equal mask blocks", 32'h1 << 5, 1'b0, 10, 1'b1, 32'h3000, 0, 1'b0, 0, 0);
        shot("R4 below mask", 32'h1 << 5, 1'b0, 11, 1'b1, 32'h3100, 0, 1'b1, 5, 10);
        shot("R5 enable off", 32'h1 << 30, 1'b0, 31, 1'b0, 32'h3200, 0, 1'b0, 0, 0);
    endtask

    task automatic t_nmi();
        shot("R6 nmi mask equal", 32'h0, 1'b1, 15, 1'b0, 32'h4000, 2, 1'b0, 0, 0);
        shot("R6 nmi ignores en", 32'h0, 1'b1, 16, 1'b0, 32'h4000, 2, 1'b1, 32, 15);
    endtask

    task automatic t_blocked_winner();
        shot("R7 tie with nmi blocked", 32'h1 << 3, 1'b1, 31, 1'b0, 32'h5000, 0, 1'b0, 0, 0);
        shot("R3 tie with nmi", 32'h1 << 3, 1'b1, 31, 1'b1, 32'h5000, 0, 1'b1, 3, 15);
        shot("R7 nmi behind maskable", 32'h1 << 30, 1'b1, 31, 1'b0, 32'h5100, 0, 1'b0, 0, 0);
    endtask

    task automatic t_no_boundary();
        irq_req  = 32'h1 << 9;
        nmi_req  = 1'b1;
        lvl_mask = 5'd31;
        irq_en   = 1'b1;
        insn_end = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            cmp("R8 no boundary", 32'(take), 32'd0);
            cmp("R9 hold num", 32'(take_num), 32'(m_num));
        end
    endtask

    task automatic t_ret_addr();
        shot("R10 code3", 32'h1 << 9, 1'b0, 31, 1'b1, 32'h6000, 3, 1'b1, 9, 4);
        shot("R10 wrap", 32'h1 << 9, 1'b0, 31, 1'b1, 32'hFFFF_FFFE, 1, 1'b1, 9, 4);
        prog(9, 31);
        shot("R11 reprogram", 32'h1 << 9, 1'b0, 31, 1'b1, 32'h7000, 0, 1'b0, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; lvl_we = 1'b0; lvl_sel = '0; lvl_wdata = '0;
        irq_req = '0; nmi_req = 1'b0; lvl_mask = '0; irq_en = 1'b0;
        insn_end = 1'b0; pc = '0; insn_len = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset_levels();
        t_priority();
        t_mask();
        t_nmi();
        t_blocked_winner();
        t_no_boundary();
        t_ret_addr();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule